// File: doc/BRIEF.md
# Edge-Serviced Watchdog Timer

This block watches a service line driven by a processor and asks the reset generator for a reset when that line stops changing. Any change on the line restarts the count, whether it rises or falls. Time is measured in ticks of a slow enable strobe that the reset generator also uses. The length of the timeout is a parameter counted in ticks, and a nominal value is 1.6 s, with a tolerated range of 1.12 s to 2.25 s. Detection of changes runs on the fast system clock, so pulses much shorter than one tick are still seen.

The block also reads the current system reset state. While the system is in reset, the count is held at zero, and counting begins from zero once reset is released. An enable input stands for the case where the service line is left floating or tri-stated. When the enable is low, the watchdog is off and never asks for a reset. An expiry is signalled by a pulse one clock wide.

The control is a three-state machine:
- `ST_HOLD`: the counter is held at zero.
- `ST_RUN`: the counter advances on each tick.
- `ST_FIRE`: the one-cycle timeout request is raised.

The machine has these transitions:
- `HOLD->RUN`: system reset is released while the enable is high.
- `RUN->HOLD` and `FIRE->HOLD`: system reset is asserted, or the enable drops.
- `RUN->RUN` with a clear: an edge is seen on the service line.
- `RUN->FIRE`: the terminal tick arrives with no edge.
- `FIRE->RUN`: leaves the fire state with the counter at zero.

Top module: `svc_watchdog`

## Requirements
- R1: When the service line shows no transition for `TIMEOUT_TICKS` ticks in `ST_RUN`, `timeout_o` is driven high. It rises in the clock cycle after the edge that takes the tick at which the count reaches `TIMEOUT_TICKS`.
- R2: A rising or a falling transition on `svc_i` clears the count. The edge reaches the state machine three clock edges after the input changes, using two synchronising flops and one flop that holds the previous value. Counting then resumes from zero.
- R3: While `sysrst_i` is 1, the count is held at zero and `timeout_o` stays 0, whatever ticks arrive.
- R4: After `sysrst_i` falls, counting starts from zero. A tick taken in the cycle of the `HOLD->RUN` transition is not counted.
- R5: A service pulse that lasts a single clock cycle, with no tick during it, is detected and clears the count.
- R6: While `wd_en_i` is 0, the count is held at zero and `timeout_o` never rises. Once it is raised again, counting starts from zero.
- R7: `timeout_o` is high for exactly one cycle per expiry. The tick in the `ST_FIRE` cycle is not counted. With ticks on every cycle, the next pulse follows `TIMEOUT_TICKS + 1` cycles later.
- R8: If a service edge and the terminal tick fall in the same cycle, the edge wins. No pulse is issued and the count restarts.
- R9: Cycles without `tick_i` do not advance the count.
- R10: While `rst_n` is 0, `timeout_o` is 0 and the state machine sits in `ST_HOLD`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| tick_i | input | 1 | Timebase enable strobe, one clock wide, shared with the reset generator |
| svc_i | input | 1 | Asynchronous service line from the processor |
| wd_en_i | input | 1 | 1 when the service line is driven; 0 turns the watchdog off |
| sysrst_i | input | 1 | 1 while the system reset is asserted |
| timeout_o | output | 1 | Single-cycle reset request on expiry |

## Verification
The main function is exercised with a set of tick streams, each with a single service toggle placed at a different point:
- No toggle: measures the bare timeout length.
- Early and mid-period toggles of both polarities: show that either edge restarts the count, and that the restart happens with the expected three-edge delay.
- A toggle timed so that its edge meets the terminal tick: tells edge priority apart from timeout priority.
- A long run with no toggle: tells a self-clearing single pulse apart from one that repeats or counts during the fire cycle.

Directed runs then cover the following:
- reset and enable holds;
- a reset released in mid-count, which tells restart-from-zero apart from resume;
- gaps in the tick stream;
- a one-clock service pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wd_state_e;

endpackage

// File: rtl/wdog_edge_sync.sv
module wdog_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic edge_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign edge_o = sync_q[SYNC_STAGES-1] ^ prev_q;

    // R2
    edge_from_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> $stable(prev_q) == 1'b0);

endmodule

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter #(
    parameter int TIMEOUT_TICKS = 1600,
    parameter int CW            = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [CW-1:0] cnt_o,
    output logic          term_o
);

    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign term_o = (cnt_q == LAST);

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hold_i,
    input  logic      edge_i,
    input  logic      tick_i,
    input  logic      term_i,
    output logic      cnt_clr_o,
    output logic      cnt_inc_o,
    output logic      fire_o,
    output wd_state_e state_o
);

    wd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: state_d = hold_i ? ST_HOLD : ST_RUN;
            ST_RUN: begin
                if (hold_i)                state_d = ST_HOLD;
                else if (edge_i)           state_d = ST_RUN;
                else if (tick_i && term_i) state_d = ST_FIRE;
                else                       state_d = ST_RUN;
            end
            ST_FIRE: state_d = hold_i ? ST_HOLD : ST_RUN;
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        cnt_clr_o = 1'b1;
        cnt_inc_o = 1'b0;
        fire_o    = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                cnt_clr_o = 1'b1;
            end
            ST_RUN: begin
                cnt_clr_o = hold_i || edge_i || (tick_i && term_i);
                cnt_inc_o = !hold_i && !edge_i && tick_i && !term_i;
            end
            ST_FIRE: begin
                fire_o    = 1'b1;
                cnt_clr_o = 1'b1;
            end
            default: cnt_clr_o = 1'b1;
        endcase
    end

    assign state_o = state_q;

    // R7
    fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

    // R8
    edge_beats_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && edge_i) |=> state_q != ST_FIRE);

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
    import wdog_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 1600,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic svc_i,
    input  logic wd_en_i,
    input  logic sysrst_i,
    output logic timeout_o
);

    localparam int CW = (TIMEOUT_TICKS > 2) ? $clog2(TIMEOUT_TICKS) : 1;

    logic          svc_edge;
    logic          hold;
    logic          cnt_clr;
    logic          cnt_inc;
    logic          term;
    logic [CW-1:0] cnt;
    wd_state_e     state;

    assign hold = sysrst_i || !wd_en_i;

    wdog_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(svc_i),
        .edge_o (svc_edge)
    );

    wdog_tick_counter #(
        .TIMEOUT_TICKS(TIMEOUT_TICKS),
        .CW           (CW)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .cnt_o (cnt),
        .term_o(term)
    );

    wdog_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_i   (hold),
        .edge_i   (svc_edge),
        .tick_i   (tick_i),
        .term_i   (term),
        .cnt_clr_o(cnt_clr),
        .cnt_inc_o(cnt_inc),
        .fire_o   (timeout_o),
        .state_o  (state)
    );

    // R3
    sysrst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sysrst_i |=> (!timeout_o && cnt == '0));

    // R6
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en_i |=> (!timeout_o && cnt == '0));

    // R9
    no_tick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !tick_i && !svc_edge && !hold) |=> $stable(cnt));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |-> (!timeout_o && state == ST_HOLD));

endmodule

// File: tb/tb_svc_watchdog.sv
`timescale 1ns/1ps
module tb_svc_watchdog;

    localparam int T = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0;
    logic svc_i = 1'b0;
    logic wd_en_i = 1'b1;
    logic sysrst_i = 1'b1;
    logic timeout_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    svc_watchdog #(.TIMEOUT_TICKS(T)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .svc_i    (svc_i),
        .wd_en_i  (wd_en_i),
        .sysrst_i (sysrst_i),
        .timeout_o(timeout_o)
    );

    // toggle step (0 = none), step count, first pulse, last pulse, pulse count
    typedef struct packed {
        int tog;
        int steps;
        int first;
        int last;
        int cnt;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{0, 12,  8,  8, 1},
        '{3, 15, 13, 13, 1},
        '{6, 18, 16, 16, 1},
        '{1, 12, 11, 11, 1},
        '{0, 20,  8, 17, 2}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic t, output logic p);
        tick_i = t;
        @(posedge clk);
        @(negedge clk);
        p = timeout_o;
        tick_i = 1'b0;
    endtask

    task automatic hold_then_release();
        logic p;
        sysrst_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(1'b1, p);
            check(p == 1'b0, "R3 no pulse in system reset", int'(p), 0);
        end
        sysrst_i = 1'b0;
        step(1'b0, p);
    endtask

    task automatic run_ticks(input int n, output int pulses, output int first);
        logic p;
        pulses = 0;
        first = 0;
        for (int s = 1; s <= n; s++) begin
            step(1'b1, p);
            if (p) begin
                pulses++;
                if (first == 0) first = s;
            end
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic p;
        int np, fp, lp;

        // R10: chip reset
        @(negedge clk);
        check(timeout_o == 1'b0, "R10 reset output", int'(timeout_o), 0);
        @(negedge clk);
        @(negedge clk);
        check(timeout_o == 1'b0, "R10 reset output held", int'(timeout_o), 0);
        rst_n = 1'b1;

        // table of tick streams with one toggle each: R1 R2 R7 R8
        foreach (VECS[k]) begin
            hold_then_release();
            np = 0; fp = 0; lp = 0;
            for (int s = 1; s <= VECS[k].steps; s++) begin
                if (s == VECS[k].tog) svc_i = ~svc_i;
                step(1'b1, p);
                if (p) begin
                    np++;
                    if (fp == 0) fp = s;
                    lp = s;
                end
            end
            check(fp == VECS[k].first, "R1/R2/R8 first pulse step", fp, VECS[k].first);
            check(lp == VECS[k].last, "R7 last pulse step", lp, VECS[k].last);
            check(np == VECS[k].cnt, "R7 pulse count", np, VECS[k].cnt);
        end

        // R3: long system reset with ticks
        sysrst_i = 1'b1;
        run_ticks(20, np, fp);
        check(np == 0, "R3 pulses during reset", np, 0);

        // R4: reset in mid-count restarts from zero
        hold_then_release();
        run_ticks(5, np, fp);
        sysrst_i = 1'b1;
        step(1'b1, p);
        sysrst_i = 1'b0;
        step(1'b1, p);
        run_ticks(T - 1, np, fp);
        check(np == 0, "R4 no early pulse after re-release", np, 0);
        step(1'b1, p);
        check(p == 1'b1, "R4 pulse after full period", int'(p), 1);

        // R6: watchdog disabled
        hold_then_release();
        wd_en_i = 1'b0;
        run_ticks(20, np, fp);
        check(np == 0, "R6 pulses while disabled", np, 0);
        wd_en_i = 1'b1;
        step(1'b0, p);
        run_ticks(T - 1, np, fp);
        check(np == 0, "R6 no early pulse after enable", np, 0);
        step(1'b1, p);
        check(p == 1'b1, "R6 pulse after enable period", int'(p), 1);

        // R9: gaps in the tick stream
        hold_then_release();
        run_ticks(T - 1, np, fp);
        np = 0;
        for (int i = 0; i < 10; i++) begin
            step(1'b0, p);
            if (p) np++;
        end
        check(np == 0, "R9 no pulse without ticks", np, 0);
        step(1'b1, p);
        check(p == 1'b1, "R9 pulse on terminal tick", int'(p), 1);

        // R5: one-clock service pulse between ticks
        hold_then_release();
        run_ticks(6, np, fp);
        svc_i = ~svc_i;
        step(1'b0, p);
        svc_i = ~svc_i;
        step(1'b0, p);
        for (int i = 0; i < 3; i++) step(1'b0, p);
        run_ticks(T - 1, np, fp);
        check(np == 0, "R5 short pulse cleared count", np, 0);
        step(1'b1, p);
        check(p == 1'b1, "R5 pulse after full period", int'(p), 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule